// File: doc/BRIEF.md
# Per-Queue Almost-Flag Status Hub

This block watches the fill level of up to eight queues that share one write port and one read port. Each queue has its own almost-full margin and almost-empty margin. For the queue currently addressed on the write side it drives a single almost-full flag. For the queue currently addressed on the read side it drives a single almost-empty flag. It also publishes two eight-bit status buses, one bit per queue, so that a monitor can see every queue's margin state whether or not that queue is selected.

Several hubs can share the two status buses. In polled mode a rotating device index advances on every edge of the bus's own clock, and a hub drives the bus only in its own slot. In direct mode the owner of each bus is an index written from that bus's own port, and the two owners are chosen independently. A hub that does not own a bus raises its enable low and presents all ones. The write-side half runs entirely on the write clock and the read-side half runs entirely on the read clock. Level counts arrive already expressed in each domain. The margin registers are loaded through a simple parallel write.

Top module: `qfh_flag_hub`

## Requirements
- R1: While a side's synchronous active-low reset is low, at the next edge of that side's clock its dedicated flag reads 1 and its status register holds all ones. All margins return to `DEF_AF_OFF` / `DEF_AE_OFF`, and the rotation index and direct owner return to 0.
- R2: One read-clock edge after the inputs are presented, `ae_n` is 0 exactly when the level of queue `rd_q` is less than or equal to that queue's almost-empty margin. Otherwise it is 1.
- R3: One write-clock edge after the inputs are presented, `af_n` is 0 exactly when the free space of queue `wr_q` is less than or equal to that queue's almost-full margin. Free space is `QDEPTH` minus the level, and it is 0 when the level is at or above `QDEPTH`. Otherwise `af_n` is 1.
- R4: A margin write (`*_off_we` high with queue index `*_off_q` and value `*_off_val`) changes only that queue's margin. It is used in comparisons from the following edge of the same clock.
- R5: Bit q of each status bus is the active-low margin flag of queue q, registered on that side's clock, for every queue whether selected or not.
- R6: Queues with an index above `qcnt_m1` are unconfigured. Their status bits read 1, and a dedicated flag that addresses such a queue reads 1.
- R7: In polled mode (`poll_mode`=1) each side's index starts at 0 after reset and advances by one per edge of its own clock. After `dev_last` it wraps to 0. The bus enable is high only when the index equals `dev_id`, and the side's sync output is high only when the index is 0.
- R8: The almost-full rotation advances only on the write clock and the almost-empty rotation advances only on the read clock. Stopping one clock freezes only that side's rotation.
- R9: In direct mode (`poll_mode`=0) an owner write (`af_own_we` on the write clock, `ae_own_we` on the read clock) sets that bus's owner index. The bus enable is high when the owner equals `dev_id`. Both sync outputs stay 0, and each owner is independent of the other.
- R10: Whenever a bus enable is low, the matching bus value reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side synchronous active-low reset |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side synchronous active-low reset |
| qcnt_m1 | input | 3 | Number of configured queues minus one |
| poll_mode | input | 1 | 1 = polled bus sharing, 0 = direct |
| dev_id | input | 3 | This hub's device index |
| dev_last | input | 3 | Highest device index in the rotation |
| af_off_we | input | 1 | Almost-full margin write strobe (wclk) |
| af_off_q | input | 3 | Queue addressed by the almost-full margin write |
| af_off_val | input | LW | Almost-full margin value |
| wr_q | input | 3 | Queue selected on the write port |
| wr_levels | input | QN*LW | Per-queue levels in the write domain, queue q at bits q*LW |
| af_own_we | input | 1 | Almost-full bus owner write strobe (wclk) |
| af_own_id | input | 3 | Almost-full bus owner index |
| af_n | output | 1 | Almost-full flag of the write-selected queue, active low |
| af_bus_n | output | 8 | Almost-full status of all queues, active low |
| af_bus_oe | output | 1 | This hub drives the almost-full bus |
| af_sync | output | 1 | Almost-full rotation is at slot 0 |
| ae_off_we | input | 1 | Almost-empty margin write strobe (rclk) |
| ae_off_q | input | 3 | Queue addressed by the almost-empty margin write |
| ae_off_val | input | LW | Almost-empty margin value |
| rd_q | input | 3 | Queue selected on the read port |
| rd_levels | input | QN*LW | Per-queue levels in the read domain, queue q at bits q*LW |
| ae_own_we | input | 1 | Almost-empty bus owner write strobe (rclk) |
| ae_own_id | input | 3 | Almost-empty bus owner index |
| ae_n | output | 1 | Almost-empty flag of the read-selected queue, active low |
| ae_bus_n | output | 8 | Almost-empty status of all queues, active low |
| ae_bus_oe | output | 1 | This hub drives the almost-empty bus |
| ae_sync | output | 1 | Almost-empty rotation is at slot 0 |

## Verification
The bench drives each comparison to the exact margin and one count either side of it. An off-by-one comparator would flip the flag at the wrong level. It also runs the full side with the level at and beyond the queue depth, where a missing clamp would wrap the free space and release the flag. It changes one queue's margin and reads a neighbour with the same level, which catches a margin bank that decodes the queue index wrongly. It shrinks the queue count to show that stale upper bits are forced inactive. It freezes the read clock while the write rotation runs, which exposes any coupling between the two rotations. In direct mode it confirms that a hub that does not own a bus presents all ones rather than leaking its status.

// File: rtl/qfh_pkg.sv
// qfh_pkg: shared constants, types and helper functions for the flag hub.
// Assumes at most eight queues and at most eight sharing devices.
package qfh_pkg;
    localparam int QMAX = 8;
    localparam int IDW  = 3;

    typedef logic [QMAX-1:0] qmask_t;
    typedef logic [IDW-1:0]  idx_t;

    // Margin test: full side measures free space, empty side measures level.
    function automatic logic level_near(input int unsigned lvl,
                                        input int unsigned off,
                                        input int unsigned depth,
                                        input logic        full_side);
        int unsigned metric;
        if (full_side) metric = (lvl >= depth) ? 0 : depth - lvl;
        else           metric = lvl;
        return metric <= off;
    endfunction

    // Mask of configured queues, bit q set when q <= cnt_m1.
    function automatic qmask_t live_mask(input idx_t cnt_m1);
        qmask_t m;
        for (int i = 0; i < QMAX; i++) m[i] = (i <= int'(cnt_m1));
        return m;
    endfunction
endpackage

// File: rtl/qfh_offset_bank.sv
// qfh_offset_bank: one margin register per queue, loaded by a parallel
// write. Assumes sel addresses a queue below QN; other values are ignored.
module qfh_offset_bank
    import qfh_pkg::*;
#(
    parameter int QN  = 8,
    parameter int OW  = 10,
    parameter int DEF = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  idx_t           sel,
    input  logic [OW-1:0]  val,
    output logic [QN*OW-1:0] offs_flat
);
    for (genvar q = 0; q < QN; q++) begin : g_q
        logic [OW-1:0] off_r;
        // Hold this queue's margin; reload on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)                         off_r <= OW'(DEF);
            else if (we && sel == idx_t'(q))    off_r <= val;
        end
        assign offs_flat[q*OW +: OW] = off_r;
    end
endmodule

// File: rtl/qfh_level_cmp.sv
// qfh_level_cmp: compares every queue's level with its margin in parallel.
// Bits for queues at or above QN read 0 (not near).
module qfh_level_cmp
    import qfh_pkg::*;
#(
    parameter int QN        = 8,
    parameter int LW        = 10,
    parameter int OW        = 10,
    parameter int DEPTH     = 512,
    parameter bit FULL_SIDE = 1'b1
) (
    input  logic [QN*LW-1:0] levels,
    input  logic [QN*OW-1:0] offs,
    output qmask_t           near
);
    for (genvar q = 0; q < QMAX; q++) begin : g_q
        if (q < QN) begin : g_live
            // Margin test for queue q.
            always_comb near[q] = level_near(32'(levels[q*LW +: LW]),
                                             32'(offs[q*OW +: OW]),
                                             DEPTH, FULL_SIDE);
        end else begin : g_absent
            // Queue slot not built.
            always_comb near[q] = 1'b0;
        end
    end
endmodule

// File: rtl/qfh_bus_share.sv
// qfh_bus_share: decides when this hub owns a shared status bus.
// Polled: rotating index 0..dev_last per clock edge. Direct: written owner.
module qfh_bus_share
    import qfh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic poll_mode,
    input  idx_t dev_id,
    input  idx_t dev_last,
    input  logic own_we,
    input  idx_t own_id,
    output logic bus_oe,
    output logic sync
);
    idx_t slot_r;
    idx_t owner_r;

    // Rotation index: advance each edge, wrap after the last device.
    always_ff @(posedge clk) begin
        if (!rst_n)                 slot_r <= '0;
        else if (slot_r >= dev_last) slot_r <= '0;
        else                        slot_r <= slot_r + idx_t'(1);
    end

    // Direct-mode owner register, written from this bus's own port.
    always_ff @(posedge clk) begin
        if (!rst_n)      owner_r <= '0;
        else if (own_we) owner_r <= own_id;
    end

    // Ownership and slot-0 marker.
    always_comb begin
        bus_oe = poll_mode ? (slot_r == dev_id) : (owner_r == dev_id);
        sync   = poll_mode && (slot_r == '0);
    end
endmodule

// File: rtl/qfh_side.sv
// qfh_side: one half of the hub (full side or empty side) on one clock.
// Holds margins, compares levels, registers the dedicated flag and the
// status word, and masks the shared bus when not owned.
module qfh_side
    import qfh_pkg::*;
#(
    parameter int QN        = 8,
    parameter int LW        = 10,
    parameter int OW        = 10,
    parameter int DEPTH     = 512,
    parameter int DEF_OFF   = 8,
    parameter bit FULL_SIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  idx_t             qcnt_m1,
    input  logic             poll_mode,
    input  idx_t             dev_id,
    input  idx_t             dev_last,
    input  logic             off_we,
    input  idx_t             off_q,
    input  logic [OW-1:0]    off_val,
    input  idx_t             sel_q,
    input  logic [QN*LW-1:0] levels,
    input  logic             own_we,
    input  idx_t             own_id,
    output logic             flag_n,
    output qmask_t           bus_n,
    output logic             bus_oe,
    output logic             sync
);
    logic [QN*OW-1:0] offs;
    qmask_t           near;
    qmask_t           live;
    qmask_t           stat_n_r;

    qfh_offset_bank #(.QN(QN), .OW(OW), .DEF(DEF_OFF)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(off_we), .sel(off_q),
        .val(off_val), .offs_flat(offs)
    );

    qfh_level_cmp #(.QN(QN), .LW(LW), .OW(OW), .DEPTH(DEPTH),
                    .FULL_SIDE(FULL_SIDE)) u_cmp (
        .levels(levels), .offs(offs), .near(near)
    );

    qfh_bus_share u_share (
        .clk(clk), .rst_n(rst_n), .poll_mode(poll_mode), .dev_id(dev_id),
        .dev_last(dev_last), .own_we(own_we), .own_id(own_id),
        .bus_oe(bus_oe), .sync(sync)
    );

    // Configured-queue mask.
    always_comb live = live_mask(qcnt_m1);

    // Dedicated flag for the selected queue, active low.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_n <= 1'b1;
        else        flag_n <= !(near[sel_q] && live[sel_q]);
    end

    // Status word for all queues, active low, unconfigured bits inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_n_r <= '1;
        else        stat_n_r <= ~(near & live);
    end

    // Present the status only while this hub owns the bus.
    always_comb bus_n = bus_oe ? stat_n_r : '1;
endmodule

// File: rtl/qfh_flag_hub.sv
// qfh_flag_hub: top of the per-queue almost-flag status hub. The write
// half runs on wclk, the read half on rclk; levels arrive per domain.
// Assumes QN <= 8 and QDEPTH fits the level width derived from it.
module qfh_flag_hub
    import qfh_pkg::*;
#(
    parameter int QN         = 8,
    parameter int QDEPTH     = 512,
    parameter int DEF_AF_OFF = 8,
    parameter int DEF_AE_OFF = 8,
    localparam int LW        = $clog2(QDEPTH + 1),
    localparam int OW        = LW
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             rclk,
    input  logic             rrst_n,
    input  logic [2:0]       qcnt_m1,
    input  logic             poll_mode,
    input  logic [2:0]       dev_id,
    input  logic [2:0]       dev_last,
    input  logic             af_off_we,
    input  logic [2:0]       af_off_q,
    input  logic [OW-1:0]    af_off_val,
    input  logic [2:0]       wr_q,
    input  logic [QN*LW-1:0] wr_levels,
    input  logic             af_own_we,
    input  logic [2:0]       af_own_id,
    output logic             af_n,
    output logic [7:0]       af_bus_n,
    output logic             af_bus_oe,
    output logic             af_sync,
    input  logic             ae_off_we,
    input  logic [2:0]       ae_off_q,
    input  logic [OW-1:0]    ae_off_val,
    input  logic [2:0]       rd_q,
    input  logic [QN*LW-1:0] rd_levels,
    input  logic             ae_own_we,
    input  logic [2:0]       ae_own_id,
    output logic             ae_n,
    output logic [7:0]       ae_bus_n,
    output logic             ae_bus_oe,
    output logic             ae_sync
);
    qfh_side #(.QN(QN), .LW(LW), .OW(OW), .DEPTH(QDEPTH),
               .DEF_OFF(DEF_AF_OFF), .FULL_SIDE(1'b1)) u_full (
        .clk(wclk), .rst_n(wrst_n), .qcnt_m1(qcnt_m1),
        .poll_mode(poll_mode), .dev_id(dev_id), .dev_last(dev_last),
        .off_we(af_off_we), .off_q(af_off_q), .off_val(af_off_val),
        .sel_q(wr_q), .levels(wr_levels), .own_we(af_own_we),
        .own_id(af_own_id), .flag_n(af_n), .bus_n(af_bus_n),
        .bus_oe(af_bus_oe), .sync(af_sync)
    );

    qfh_side #(.QN(QN), .LW(LW), .OW(OW), .DEPTH(QDEPTH),
               .DEF_OFF(DEF_AE_OFF), .FULL_SIDE(1'b0)) u_empty (
        .clk(rclk), .rst_n(rrst_n), .qcnt_m1(qcnt_m1),
        .poll_mode(poll_mode), .dev_id(dev_id), .dev_last(dev_last),
        .off_we(ae_off_we), .off_q(ae_off_q), .off_val(ae_off_val),
        .sel_q(rd_q), .levels(rd_levels), .own_we(ae_own_we),
        .own_id(ae_own_id), .flag_n(ae_n), .bus_n(ae_bus_n),
        .bus_oe(ae_bus_oe), .sync(ae_sync)
    );
endmodule

// File: rtl/qfh_flag_hub_chk.sv
// qfh_flag_hub_chk: port-level properties of the flag hub, bound to the top.
module qfh_flag_hub_chk
    import qfh_pkg::*;
(
    input logic       wclk,
    input logic       wrst_n,
    input logic       rclk,
    input logic       rrst_n,
    input logic [2:0] qcnt_m1,
    input logic       poll_mode,
    input logic [2:0] dev_id,
    input logic [2:0] dev_last,
    input logic [2:0] wr_q,
    input logic [2:0] rd_q,
    input logic       af_n,
    input logic       ae_n,
    input logic [7:0] af_bus_n,
    input logic       af_bus_oe,
    input logic       af_sync,
    input logic [7:0] ae_bus_n,
    input logic       ae_bus_oe,
    input logic       ae_sync
);
    assert_af_release_R10: assert property (@(posedge wclk) disable iff (!wrst_n)
        !af_bus_oe |-> af_bus_n == 8'hFF);
    assert_ae_release_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
        !ae_bus_oe |-> ae_bus_n == 8'hFF);

    assert_af_unused_bits_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        $stable(qcnt_m1) |-> (af_bus_n | live_mask(qcnt_m1)) == 8'hFF);
    assert_ae_unused_bits_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        $stable(qcnt_m1) |-> (ae_bus_n | live_mask(qcnt_m1)) == 8'hFF);

    assert_af_unused_sel_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        ($stable(wr_q) && $stable(qcnt_m1) && wr_q > qcnt_m1) |-> af_n);
    assert_ae_unused_sel_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        ($stable(rd_q) && $stable(qcnt_m1) && rd_q > qcnt_m1) |-> ae_n);

    assert_af_direct_nosync_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
        !poll_mode |-> !af_sync);
    assert_ae_direct_nosync_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
        !poll_mode |-> !ae_sync);

    assert_af_poll_advance_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
        (poll_mode && af_sync && dev_last != 3'd0) |=> (!af_sync || !poll_mode));
    assert_af_slot0_owner_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
        (poll_mode && af_sync && af_bus_oe) |-> dev_id == 3'd0);
endmodule

bind qfh_flag_hub qfh_flag_hub_chk u_chk (.*);

// File: tb/qfh_flag_hub_tb.sv
module qfh_flag_hub_tb;
    localparam int QN = 8;
    localparam int LW = 10;

    logic wclk = 1'b0, rclk = 1'b0, rclk_en = 1'b1;
    logic wrst_n = 1'b0, rrst_n = 1'b0;
    logic [2:0] qcnt_m1 = 3'd7, dev_id = 3'd0, dev_last = 3'd0;
    logic poll_mode = 1'b1;
    logic af_off_we = 1'b0, ae_off_we = 1'b0, af_own_we = 1'b0, ae_own_we = 1'b0;
    logic [2:0] af_off_q = '0, ae_off_q = '0, wr_q = '0, rd_q = '0;
    logic [2:0] af_own_id = '0, ae_own_id = '0;
    logic [LW-1:0] af_off_val = '0, ae_off_val = '0;
    logic [QN*LW-1:0] wr_levels, rd_levels;
    logic af_n, ae_n, af_bus_oe, ae_bus_oe, af_sync, ae_sync;
    logic [7:0] af_bus_n, ae_bus_n;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 wclk = ~wclk;
    always #2.5 rclk = rclk_en ? ~rclk : 1'b0;

    qfh_flag_hub u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wtick(); @(posedge wclk); #1; endtask
    task automatic rtick(); @(posedge rclk); #1; endtask

    task automatic calm_levels();
        for (int q = 0; q < QN; q++) begin
            wr_levels[q*LW +: LW] = 10'd100;
            rd_levels[q*LW +: LW] = 10'd100;
        end
    endtask

    task automatic reset_both();
        wrst_n = 1'b0; rrst_n = 1'b0;
        wtick(); wtick();
        wrst_n = 1'b1; rrst_n = 1'b1;
    endtask

    // R1: reset dominates a level that would otherwise assert the flags
    task automatic test_reset();
        calm_levels();
        rd_levels[0 +: LW] = 10'd0;
        wr_levels[0 +: LW] = 10'd512;
        wrst_n = 1'b0; rrst_n = 1'b0;
        wtick(); wtick();
        check("R1 af_n in reset", af_n, 1);
        check("R1 ae_n in reset", ae_n, 1);
        check("R1 af_bus_n in reset", af_bus_n, 8'hFF);
        check("R1 ae_bus_n in reset", ae_bus_n, 8'hFF);
        check("R1 af_sync slot0 in reset", af_sync, 1);
        wrst_n = 1'b1; rrst_n = 1'b1;
        calm_levels();
        wtick(); wtick();
    endtask

    // R2: almost-empty boundary around the default margin of 8
    task automatic test_ae();
        rd_q = 3'd2;
        rd_levels[2*LW +: LW] = 10'd8;  rtick();
        check("R2 level==margin", ae_n, 0);
        rd_levels[2*LW +: LW] = 10'd9;  rtick();
        check("R2 level==margin+1", ae_n, 1);
        rd_levels[2*LW +: LW] = 10'd0;  rtick();
        check("R2 level 0", ae_n, 0);
        calm_levels(); rd_q = 3'd0; rtick();
    endtask

    // R3: almost-full boundary, including the at-depth clamp
    task automatic test_af();
        wr_q = 3'd5;
        wr_levels[5*LW +: LW] = 10'd504; wtick();
        check("R3 free==margin", af_n, 0);
        wr_levels[5*LW +: LW] = 10'd503; wtick();
        check("R3 free==margin+1", af_n, 1);
        wr_levels[5*LW +: LW] = 10'd512; wtick();
        check("R3 level at depth", af_n, 0);
        wr_levels[5*LW +: LW] = 10'd600; wtick();
        check("R3 level beyond depth", af_n, 0);
        calm_levels(); wr_q = 3'd0; wtick();
    endtask

    // R4: margin write touches only the addressed queue
    task automatic test_offset();
        ae_off_we = 1'b1; ae_off_q = 3'd3; ae_off_val = 10'd20;
        rtick();
        ae_off_we = 1'b0;
        rd_levels[3*LW +: LW] = 10'd15;
        rd_levels[4*LW +: LW] = 10'd15;
        rd_q = 3'd3; rtick();
        check("R4 new margin on queue 3", ae_n, 0);
        rd_q = 3'd4; rtick();
        check("R4 queue 4 keeps default margin", ae_n, 1);
        af_off_we = 1'b1; af_off_q = 3'd6; af_off_val = 10'd0;
        wtick();
        af_off_we = 1'b0;
        wr_levels[6*LW +: LW] = 10'd511; wr_q = 3'd6; wtick();
        check("R4 af margin 0, free 1", af_n, 1);
        calm_levels(); rd_q = 3'd0; wr_q = 3'd0; rtick(); wtick();
    endtask

    // R5: status bus shows unselected queues
    task automatic test_bus();
        rd_levels[1*LW +: LW] = 10'd0;
        rd_levels[6*LW +: LW] = 10'd3;
        wr_levels[7*LW +: LW] = 10'd510;
        rd_q = 3'd0; wr_q = 3'd0;
        rtick(); wtick();
        check("R5 ae bus unselected queues", ae_bus_n, 8'hBD);
        check("R5 af bus unselected queue", af_bus_n, 8'h7F);
        check("R5 af_n for calm selected queue", af_n, 1);
        calm_levels(); rtick(); wtick();
    endtask

    // R6: unconfigured queues stay inactive
    task automatic test_qcnt();
        qcnt_m1 = 3'd3;
        for (int q = 0; q < QN; q++) rd_levels[q*LW +: LW] = 10'd0;
        rd_q = 3'd5; rtick(); rtick();
        check("R6 bus upper bits inactive", ae_bus_n, 8'hF0);
        check("R6 flag for unconfigured queue", ae_n, 1);
        rd_q = 3'd2; rtick();
        check("R6 flag for configured queue", ae_n, 0);
        qcnt_m1 = 3'd7; calm_levels(); rd_q = 3'd0; rtick();
    endtask

    // R7, R8: polled rotation per clock, frozen read clock
    task automatic test_poll();
        dev_last = 3'd2; dev_id = 3'd1; poll_mode = 1'b1;
        calm_levels();
        wr_levels[0 +: LW] = 10'd510;
        reset_both();
        rclk_en = 1'b0;
        for (int k = 0; k < 7; k++) begin
            check("R7 af_bus_oe slot", af_bus_oe, (k % 3) == 1);
            check("R7 af_sync slot0", af_sync, (k % 3) == 0);
            check("R7 af_bus_n value", af_bus_n, ((k % 3) == 1) ? 8'hFE : 8'hFF);
            wtick();
        end
        check("R8 ae rotation frozen sync", ae_sync, 1);
        check("R8 ae rotation frozen oe", ae_bus_oe, 0);
        rclk_en = 1'b1;
        rtick();
        check("R8 ae rotation advances on rclk", ae_bus_oe, 1);
        check("R8 ae sync clears", ae_sync, 0);
        calm_levels(); wtick();
    endtask

    // R9, R10: direct owners chosen per port
    task automatic test_direct();
        poll_mode = 1'b0; dev_id = 3'd2; dev_last = 3'd0;
        rd_levels[0 +: LW] = 10'd0;
        rtick(); wtick();
        check("R9 owner 0 after reset, not owned", af_bus_oe, 0);
        check("R9 no sync in direct", af_sync | ae_sync, 0);
        af_own_we = 1'b1; af_own_id = 3'd2; wtick(); af_own_we = 1'b0;
        ae_own_we = 1'b1; ae_own_id = 3'd5; rtick(); ae_own_we = 1'b0;
        check("R9 af owned", af_bus_oe, 1);
        check("R9 ae owner independent", ae_bus_oe, 0);
        check("R10 released bus all ones", ae_bus_n, 8'hFF);
        ae_own_we = 1'b1; ae_own_id = 3'd2; rtick(); ae_own_we = 1'b0;
        check("R9 ae owned", ae_bus_oe, 1);
        check("R5 ae bus when owned", ae_bus_n, 8'hFE);
        calm_levels(); rtick();
    endtask

    initial begin
        calm_levels();
        test_reset();
        test_ae();
        test_af();
        test_offset();
        test_bus();
        test_qcnt();
        test_poll();
        test_direct();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule